// File: doc/BRIEF.md
# Synchronous Pipelined Burst SRAM

This block is a synthesizable model of a single-cycle-deselect synchronous burst SRAM. It is organised as words of four 9-bit lanes, each lane holding 8 data bits and a parity bit. Every control, the address and the write data are taken on the rising clock edge. An address strobe loads a new external address. On later cycles a 2-bit burst counter either steps the low address bits or holds them.

A global write stores a whole word. A byte-write path stores only the lanes whose enables are low. Read data passes through an array read register and then an output register, so it appears after two edges. An asynchronous output enable gates it, and the gated result is shown on a separate valid flag.

A snooze input freezes the whole model. The array keeps its contents, and every other input is ignored while snooze is high.

Top module: `sync_burst_sram`

## Requirements
- R1: A read whose address is taken at edge k shows its word on `dout` with `dout_vld` high after edge k+1, and not after edge k alone.
- R2: When `gw_n` is low on a non-strobe cycle of a live burst, all 36 bits, including every parity bit, are written. The values of `bwe_n` and `bw_n` do not matter.
- R3: With `gw_n` high and `bwe_n` low, lane i (bits 9i+8..9i, where bit 9i+8 is the parity bit) is written only if `bw_n[i]` is low. With both `gw_n` and `bwe_n` high, the cycle is a read and nothing is written.
- R4: A strobe cycle (`ads_n` low) selects the device only if `ce1_n`=0, `ce2_n`=0 and `ce3`=1. The three enables are ignored on cycles where `ads_n` is high.
- R5: On a non-strobe cycle of a live burst, `adv_n` low increments the low 2 address bits. They wrap from 3 to 0, and the upper bits stay unchanged. With `adv_n` high, the same address is accessed again as a wait state.
- R6: A strobe cycle never writes. The next cycle, with `adv_n` high, writes the address that was just loaded.
- R7: A strobe cycle that does not select the device ends the burst. Later non-strobe cycles then do no reads and no writes until a selecting strobe arrives.
- R8: While `snooze` is high, the array, the burst state and the pipeline hold their values and all other inputs are ignored, with `dout_vld` low. When `snooze` falls, the held output returns.
- R9: `oe_n` high forces `dout_vld` low and `dout` to zero at once, without waiting for a clock edge.
- R10: After reset, no burst is live and `dout_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control and pipeline state |
| addr | input | ADDR_W | External word address, loaded on strobe cycles |
| wdata | input | LANES*LANE_W | Write data, lane i at bits 9i+8..9i |
| ce1_n | input | 1 | Active-low chip enable, sampled on strobe cycles |
| ce2_n | input | 1 | Second active-low chip enable, sampled on strobe cycles |
| ce3 | input | 1 | Active-high chip enable, sampled on strobe cycles |
| ads_n | input | 1 | Active-low address strobe |
| adv_n | input | 1 | Active-low burst advance |
| gw_n | input | 1 | Active-low global write |
| bwe_n | input | 1 | Active-low byte-write enable |
| bw_n | input | LANES | Active-low per-lane write enables |
| snooze | input | 1 | Active-high standby, asynchronous freeze |
| oe_n | input | 1 | Active-low asynchronous output enable |
| dout | output | LANES*LANE_W | Read data, zero when not valid |
| dout_vld | output | 1 | High when `dout` carries a driven read word |

## Verification
The bench builds the block with ADDR_W=6, which gives a 64-word array, and keeps the default four 9-bit lanes. A word therefore spans 36 bits and all four lane enables are exercised, including each parity bit. With the small array, bursts can start partway through an aligned group near the top of the address range, at 0x32. This exposes the 3-to-0 wrap next to a neighbouring word, 0x34, which must stay untouched.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    function automatic logic [BURST_W-1:0] burst_inc(input logic [BURST_W-1:0] cnt);
        return cnt + 1'b1;
    endfunction

endpackage

// File: rtl/sbs_lane_decode.sv
module sbs_lane_decode #(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_mask
);

    always_comb begin
        if (!gw_n) begin
            lane_mask = '1;
        end else if (!bwe_n) begin
            lane_mask = ~bw_n;
        end else begin
            lane_mask = '0;
        end
    end

endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              strobe_n,
    input  logic              sel,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic              live_q,
    output logic [ADDR_W-1:0] cur_q,
    output logic              acc_vld,
    output logic [ADDR_W-1:0] acc_addr
);

    localparam int HI_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic              live;
        logic [ADDR_W-1:0] addr;
    } bst_t;

    bst_t s_d, s_q;
    logic [ADDR_W-1:0] stepped;

    always_comb begin
        stepped  = {s_q.addr[ADDR_W-1 -: HI_W], burst_inc(s_q.addr[BURST_W-1:0])};
        s_d      = s_q;
        acc_vld  = 1'b0;
        acc_addr = s_q.addr;
        if (!strobe_n) begin
            acc_vld  = sel;
            acc_addr = ext_addr;
            s_d.live = sel;
            s_d.addr = sel ? ext_addr : '0;
        end else if (s_q.live) begin
            acc_vld  = 1'b1;
            acc_addr = adv_n ? s_q.addr : stepped;
            s_d.addr = acc_addr;
        end
        if (!en) begin
            s_d = s_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign live_q = s_q.live;
    assign cur_q  = s_q.addr;

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      en,
    input  logic [LANES-1:0]          we_mask,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rdata_q
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_l [DEPTH];
        logic [LANE_W-1:0] rd_l_q;

        always_ff @(posedge clk) begin
            if (en && we_mask[g]) begin
                mem_l[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        always_ff @(posedge clk) begin
            if (en && rd_en) begin
                rd_l_q <= mem_l[addr];
            end
        end

        assign rdata_q[g*LANE_W +: LANE_W] = rd_l_q;
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    ce1_n,
    input  logic                    ce2_n,
    input  logic                    ce3,
    input  logic                    ads_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    snooze,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_vld
);

    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        logic              vld1;
        logic              vld2;
        logic [WORD_W-1:0] data;
    } pipe_t;

    logic              run_en;
    logic              sel;
    logic              burst_live;
    logic [ADDR_W-1:0] burst_addr;
    logic              acc_vld;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  lane_mask;
    logic [LANES-1:0]  we_mask;
    logic              rd_en;
    logic [WORD_W-1:0] arr_rdata;
    acc_e              acc_kind;
    pipe_t             p_d, p_q;

    assign run_en = !snooze;
    assign sel    = !ce1_n && !ce2_n && ce3;

    sbs_burst_seq #(.ADDR_W(ADDR_W)) burst_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (run_en),
        .strobe_n (ads_n),
        .sel      (sel),
        .adv_n    (adv_n),
        .ext_addr (addr),
        .live_q   (burst_live),
        .cur_q    (burst_addr),
        .acc_vld  (acc_vld),
        .acc_addr (acc_addr)
    );

    sbs_lane_decode #(.LANES(LANES)) decode_i (
        .gw_n      (gw_n),
        .bwe_n     (bwe_n),
        .bw_n      (bw_n),
        .lane_mask (lane_mask)
    );

    always_comb begin
        if (!run_en || !acc_vld) begin
            acc_kind = ACC_NONE;
        end else if (ads_n && (|lane_mask)) begin
            acc_kind = ACC_WRITE;
        end else begin
            acc_kind = ACC_READ;
        end
        we_mask = (acc_kind == ACC_WRITE) ? lane_mask : '0;
        rd_en   = (acc_kind == ACC_READ);
    end

    sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
        .clk     (clk),
        .en      (run_en),
        .we_mask (we_mask),
        .rd_en   (rd_en),
        .addr    (acc_addr),
        .wdata   (wdata),
        .rdata_q (arr_rdata)
    );

    always_comb begin
        p_d = p_q;
        if (run_en) begin
            p_d.vld1 = rd_en;
            p_d.vld2 = p_q.vld1;
            p_d.data = arr_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign dout_vld = !oe_n && !snooze && p_q.vld2;
    assign dout     = dout_vld ? p_q.data : '0;

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       addr,
    input logic                    ce1_n,
    input logic                    ce2_n,
    input logic                    ce3,
    input logic                    ads_n,
    input logic                    adv_n,
    input logic                    snooze,
    input logic                    oe_n,
    input logic [LANES*LANE_W-1:0] dout,
    input logic                    dout_vld,
    input logic                    burst_live,
    input logic [ADDR_W-1:0]       burst_addr,
    input logic [LANES-1:0]        we_mask
);

    logic chk_sel;
    assign chk_sel = !ce1_n && !ce2_n && ce3;

    assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!dout_vld && dout == '0));

    assert_snooze_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snooze |-> !dout_vld);

    assert_snooze_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snooze |=> ($stable(burst_addr) && $stable(burst_live)));

    assert_burst_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_live && ads_n && !adv_n && !snooze) |=>
            (burst_addr[1:0] == $past(burst_addr[1:0]) + 2'd1 &&
             burst_addr[ADDR_W-1:2] == $past(burst_addr[ADDR_W-1:2])));

    assert_burst_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_live && ads_n && adv_n && !snooze) |=> $stable(burst_addr));

    assert_strobe_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |-> (we_mask == '0));

    assert_select_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_n && !snooze && chk_sel) |=> (burst_live && burst_addr == $past(addr)));

    assert_deselect_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_n && !snooze && !chk_sel) |=> !burst_live);

    assert_idle_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_live && ads_n) |-> (we_mask == '0));

endmodule

bind sync_burst_sram sbs_checker #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .ce1_n      (ce1_n),
    .ce2_n      (ce2_n),
    .ce3        (ce3),
    .ads_n      (ads_n),
    .adv_n      (adv_n),
    .snooze     (snooze),
    .oe_n       (oe_n),
    .dout       (dout),
    .dout_vld   (dout_vld),
    .burst_live (burst_live),
    .burst_addr (burst_addr),
    .we_mask    (we_mask)
);

// File: tb/sync_burst_sram_tb_top.sv
module sync_burst_sram_tb_top;

    localparam int AW = 6;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int WW = LN * LW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic [WW-1:0] wdata;
    logic          ce1_n, ce2_n, ce3, ads_n, adv_n, gw_n, bwe_n, snooze, oe_n;
    logic [LN-1:0] bw_n;
    logic [WW-1:0] dout;
    logic          dout_vld;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .ce1_n(ce1_n), .ce2_n(ce2_n), .ce3(ce3), .ads_n(ads_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .snooze(snooze), .oe_n(oe_n),
        .dout(dout), .dout_vld(dout_vld)
    );

    task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_ctl();
        ads_n = 1'b1; adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
        ce1_n = 1'b0; ce2_n = 1'b0; ce3 = 1'b1; snooze = 1'b0; oe_n = 1'b0;
    endtask

    task automatic desel();
        ads_n = 1'b0; ce1_n = 1'b1;
        cyc();
        idle_ctl();
    endtask

    task automatic wr_word(input logic [AW-1:0] a, input logic [WW-1:0] d);
        ads_n = 1'b0; addr = a;
        cyc();
        ads_n = 1'b1; gw_n = 1'b0; wdata = d;
        cyc();
        gw_n = 1'b1;
        desel();
    endtask

    task automatic rd_word(input logic [AW-1:0] a, output logic [WW-1:0] d, output logic v);
        ads_n = 1'b0; addr = a;
        cyc();
        ads_n = 1'b1;
        cyc();
        d = dout; v = dout_vld;
        desel();
    endtask

    function automatic logic [WW-1:0] merge(input logic [WW-1:0] old_w, input logic [WW-1:0] new_w,
                                            input logic [LN-1:0] lanes);
        logic [WW-1:0] r = old_w;
        for (int i = 0; i < LN; i++) begin
            if (lanes[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
        end
        return r;
    endfunction

    task automatic test_global_and_latency();
        logic [WW-1:0] d; logic v;
        // R2: global write overrides byte controls set to "write nothing"
        ads_n = 1'b0; addr = 6'h10; cyc();
        ads_n = 1'b1; gw_n = 1'b0; bwe_n = 1'b0; bw_n = 4'hF; wdata = 36'h9_1234_5678; cyc();
        idle_ctl(); desel();
        cyc(); cyc();
        // R1: two-edge latency from a quiet pipeline
        ads_n = 1'b0; addr = 6'h10; cyc();
        chk("R1 no data after one edge", {35'd0, dout_vld}, 36'd0);
        ads_n = 1'b1; cyc();
        chk("R1 valid after two edges", {35'd0, dout_vld}, 36'd1);
        chk("R2 global write word", dout, 36'h9_1234_5678);
        desel();
        rd_word(6'h10, d, v);
        chk("R2 readback", d, 36'h9_1234_5678);
    endtask

    task automatic test_byte_write();
        logic [WW-1:0] d; logic v;
        wr_word(6'h20, '1);
        // R3: lanes 0 and 2 written (bw_n=4'b1010), parity included
        ads_n = 1'b0; addr = 6'h20; cyc();
        ads_n = 1'b1; bwe_n = 1'b0; bw_n = 4'b1010; wdata = '0; cyc();
        idle_ctl(); desel();
        rd_word(6'h20, d, v);
        chk("R3 byte lanes 0,2", d, merge('1, '0, 4'b0101));
        // R3: bwe_n high with gw_n high means read, no write
        ads_n = 1'b0; addr = 6'h20; cyc();
        ads_n = 1'b1; bwe_n = 1'b1; bw_n = 4'h0; wdata = 36'h0_5555_5555; cyc();
        idle_ctl(); desel();
        rd_word(6'h20, d, v);
        chk("R3 bwe_n high no write", d, merge('1, '0, 4'b0101));
    endtask

    task automatic test_burst();
        logic [WW-1:0] d; logic v;
        logic [WW-1:0] w [4];
        for (int i = 0; i < 4; i++) w[i] = 36'h1_0000_0000 + 36'(i * 36'h1111);
        wr_word(6'h34, 36'h3_ABCD_EF01);
        // R5: burst write from 0x32 wraps to 0x30, 0x31
        ads_n = 1'b0; addr = 6'h32; cyc();
        ads_n = 1'b1; gw_n = 1'b0; adv_n = 1'b1; wdata = w[2]; cyc();
        adv_n = 1'b0; wdata = w[3]; cyc();
        wdata = w[0]; cyc();
        wdata = w[1]; cyc();
        idle_ctl(); desel();
        for (int i = 0; i < 4; i++) begin
            rd_word(6'h30 + 6'(i), d, v);
            chk("R5 burst write wrap", d, w[i]);
        end
        rd_word(6'h34, d, v);
        chk("R5 upper bits unchanged", d, 36'h3_ABCD_EF01);
        // R5: burst read with advance, then wait state
        ads_n = 1'b0; addr = 6'h32; cyc();
        ads_n = 1'b1; adv_n = 1'b0; cyc();
        chk("R5 burst read 0x32", dout, w[2]);
        cyc();
        chk("R5 burst read 0x33", dout, w[3]);
        cyc();
        chk("R5 burst read wrap 0x30", dout, w[0]);
        adv_n = 1'b1; cyc();
        chk("R5 burst read 0x31", dout, w[1]);
        cyc();
        chk("R5 wait state repeats 0x31", dout, w[1]);
        idle_ctl(); desel();
    endtask

    task automatic test_strobe_write();
        logic [WW-1:0] d; logic v;
        wr_word(6'h08, 36'h0_AAAA_0001);
        // R6: write controls on the strobe cycle are ignored
        ads_n = 1'b0; addr = 6'h08; gw_n = 1'b0; wdata = 36'h0_BBBB_0002; cyc();
        gw_n = 1'b1; ads_n = 1'b1; cyc();
        idle_ctl(); desel();
        rd_word(6'h08, d, v);
        chk("R6 strobe cycle no write", d, 36'h0_AAAA_0001);
        // R6: next cycle with adv_n high writes the loaded address
        ads_n = 1'b0; addr = 6'h08; cyc();
        ads_n = 1'b1; adv_n = 1'b1; gw_n = 1'b0; wdata = 36'h0_CCCC_0003; cyc();
        idle_ctl(); desel();
        rd_word(6'h08, d, v);
        chk("R6 write at loaded address", d, 36'h0_CCCC_0003);
    endtask

    task automatic test_select();
        logic [WW-1:0] d; logic v;
        // R4: each enable alone deselects on a strobe
        ads_n = 1'b0; addr = 6'h10; ce2_n = 1'b1; cyc();
        idle_ctl(); cyc(); cyc();
        chk("R4 ce2_n high deselects", {35'd0, dout_vld}, 36'd0);
        ads_n = 1'b0; addr = 6'h10; ce3 = 1'b0; cyc();
        idle_ctl(); cyc(); cyc();
        chk("R4 ce3 low deselects", {35'd0, dout_vld}, 36'd0);
        // R4: enables ignored on non-strobe cycles
        ads_n = 1'b0; addr = 6'h0A; cyc();
        ads_n = 1'b1; ce1_n = 1'b1; ce3 = 1'b0; gw_n = 1'b0; wdata = 36'h7_0A0A_0A0A; cyc();
        idle_ctl(); desel();
        rd_word(6'h0A, d, v);
        chk("R4 enables ignored mid-burst", d, 36'h7_0A0A_0A0A);
    endtask

    task automatic test_deselect();
        logic [WW-1:0] d; logic v;
        wr_word(6'h00, 36'h4_0000_0E0E);
        // R7: after a deselecting strobe, writes are dropped
        desel();
        ads_n = 1'b1; gw_n = 1'b0; wdata = 36'h5_DEAD_BEEF; cyc();
        adv_n = 1'b0; cyc();
        idle_ctl();
        chk("R7 no read while deselected", {35'd0, dout_vld}, 36'd0);
        rd_word(6'h00, d, v);
        chk("R7 addr 0 untouched", d, 36'h4_0000_0E0E);
        rd_word(6'h0A, d, v);
        chk("R7 addr 0x0A untouched", d, 36'h7_0A0A_0A0A);
    endtask

    task automatic test_oe_snooze();
        logic [WW-1:0] d; logic v;
        wr_word(6'h05, 36'h6_1357_9BDF);
        wr_word(6'h06, 36'h2_2468_ACE0);
        ads_n = 1'b0; addr = 6'h05; cyc();
        ads_n = 1'b1; cyc();
        chk("R1 setup read 0x05", dout, 36'h6_1357_9BDF);
        // R9: output enable acts without a clock edge
        oe_n = 1'b1; #1;
        chk("R9 oe_n high data zero", dout, '0);
        chk("R9 oe_n high not valid", {35'd0, dout_vld}, 36'd0);
        oe_n = 1'b0; #1;
        chk("R9 oe_n low restores", dout, 36'h6_1357_9BDF);
        // R8: snooze freezes and ignores inputs
        snooze = 1'b1; ads_n = 1'b0; addr = 6'h06; gw_n = 1'b0; adv_n = 1'b0;
        wdata = 36'h0; #1;
        chk("R8 snooze output low", {35'd0, dout_vld}, 36'd0);
        cyc(); cyc();
        chk("R8 still low in snooze", {35'd0, dout_vld}, 36'd0);
        idle_ctl(); #1;
        chk("R8 held word returns", dout, 36'h6_1357_9BDF);
        chk("R8 held valid returns", {35'd0, dout_vld}, 36'd1);
        desel();
        rd_word(6'h06, d, v);
        chk("R8 no write in snooze", d, 36'h2_2468_ACE0);
    endtask

    initial begin
        addr = '0; wdata = '0;
        idle_ctl();
        rst_n = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        chk("R10 reset output idle", {35'd0, dout_vld}, 36'd0);
        test_global_and_latency();
        test_byte_write();
        test_burst();
        test_strobe_write();
        test_select();
        test_deselect();
        test_oe_snooze();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule